// File: doc/BRIEF.md
# PWM Action Qualifier with Continuous Force Override

This block turns a time-base count into two pulse-width-modulated outputs, A and B. A separate time-base unit supplies the count value, its direction, the zero and period strobes and a prescaled tick. On each tick the block decides, for each output, whether any event on that tick requests an action. The events are counter at zero, counter at period, counter equal to compare A while counting up, and counter equal to compare B while counting up. The chosen action can drive the output low, drive it high or toggle it. Each output has its own action word, so either edge of either output can be placed on any of the four events.

A continuous force register can hold either output at a fixed level whatever the action logic does. The action logic keeps running underneath the force, so releasing the force brings back the level that the actions have produced in the meantime. The force value is written to a shadow. A reload-mode field picks when the shadow takes effect: at zero, at period, at either of the two, or on the next tick. The compare registers are also shadowed and load at a zero tick, so a new duty value never cuts a period short.

All configuration arrives over a single-cycle write port that takes an address and a data word.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both outputs are low, no force is active, both compare values and both action words are zero.
- R2: Action codes are 2 bits: 00 keeps the level, 01 drives low, 10 drives high, 11 inverts. Bits [1:0] of an action word give the code for a tick that carries the zero strobe.
- R3: Bits [3:2] of an action word give the code for a tick that carries the period strobe.
- R4: Bits [5:4] give the code for a tick where the count equals active compare A and the direction input is 1 (up). Bits [9:8] do the same for compare B. A match while counting down (direction 0) has no effect. Output A uses the word at address 2 and output B the word at address 3. Compare A is at address 0 and compare B at address 1.
- R5: When several events coincide on one tick, the output takes the code of the highest-priority event whose code is not 00. The order is compare B, then compare A, then period, then zero.
- R6: Without a tick, no action, compare load or force load takes place, and both outputs hold their level.
- R7: A write to a compare address goes to a shadow. The shadow is copied into the active compare only on a tick that carries the zero strobe. Events on that tick still use the old active value.
- R8: The force register is at address 4. Bits [1:0] apply to output A and bits [3:2] to output B. Code 01 holds the output low, 10 holds it high, and 00 or 11 leaves it to the action logic.
- R9: Force bits [7:6] select when the written force codes become active, always on a tick. 00 loads at a zero tick, 01 at a period tick, 10 at either, and 11 on the next tick of any kind.
- R10: While a force is active the action logic keeps updating the level underneath. When the force is released, the output shows that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled time-base tick; all events qualify on it |
| cnt | input | CNT_W | Current time-base count |
| cnt_up | input | 1 | Count direction, 1 = counting up |
| evt_zero | input | 1 | Count-at-zero strobe |
| evt_period | input | 1 | Count-at-period strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (0..4) |
| wr_data | input | CNT_W | Register write data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The hardest situation to reach is a tick on which all four events meet: both compares equal the count, both strobes are high and the direction is up. Priority is only visible in that case. The bench loads both compares with the same value through a zero tick. It then applies such a tick once for every one of the 256 code combinations, with output B's word holding the combinations in a different order from output A's. A second hard case is a force that hides action activity. The bench sweeps every force code against every reload mode while a period action toggles the hidden level, then releases the force and compares the revealed level with its own model.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  // per-output action word, decoded from wr_data bits 9:8, 5:4, 3:2, 1:0
  typedef struct packed {
    logic [1:0] on_cmpb;
    logic [1:0] on_cmpa;
    logic [1:0] on_prd;
    logic [1:0] on_zro;
  } act_word_t;

  localparam int unsigned ADDR_CMP_A = 0;
  localparam int unsigned ADDR_CMP_B = 1;
  localparam int unsigned ADDR_ACT_A = 2;
  localparam int unsigned ADDR_ACT_B = 3;
  localparam int unsigned ADDR_FRC   = 4;

  localparam int unsigned N_OUT = 2;

  function automatic logic apply_action(input logic cur, input logic [1:0] code);
    case (code)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  // highest priority event that asks for something wins
  function automatic logic [1:0] pick_action(input act_word_t w, input logic ev_zro,
                                             input logic ev_prd, input logic ev_ca,
                                             input logic ev_cb);
    if (ev_cb && w.on_cmpb != ACT_NONE) return w.on_cmpb;
    if (ev_ca && w.on_cmpa != ACT_NONE) return w.on_cmpa;
    if (ev_prd && w.on_prd != ACT_NONE) return w.on_prd;
    if (ev_zro && w.on_zro != ACT_NONE) return w.on_zro;
    return ACT_NONE;
  endfunction

  function automatic logic reload_due(input logic [1:0] mode, input logic ev_zro,
                                      input logic ev_prd);
    case (mode)
      2'b00:   return ev_zro;
      2'b01:   return ev_prd;
      2'b10:   return ev_zro | ev_prd;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic force_on(input logic [1:0] f);
    return (f == 2'b01) || (f == 2'b10);
  endfunction

endpackage

// File: rtl/pwmq_regs.sv
module pwmq_regs
  import pwmq_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         evt_zero,
  input  logic                         evt_period,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [CNT_W-1:0]             wr_data,
  output logic [N_OUT-1:0][CNT_W-1:0]  cmp_sh,
  output logic [N_OUT-1:0][CNT_W-1:0]  cmp_act,
  output act_word_t [N_OUT-1:0]        act_word,
  output logic [N_OUT-1:0][1:0]        frc_act
);

  localparam int unsigned FRC_SH_W = 2;

  logic                         zero_tick;
  logic                         frc_load;
  logic                         frc_wr;
  logic [1:0]                   rld_mode;
  logic [N_OUT-1:0][FRC_SH_W-1:0] frc_sh;

  assign zero_tick = tick & evt_zero;
  assign frc_wr    = wr_en && (wr_addr == ADDR_W'(ADDR_FRC));
  assign frc_load  = tick && reload_due(rld_mode, evt_zero, evt_period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rld_mode <= 2'b00;
    else if (frc_wr) rld_mode <= wr_data[7:6];
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_ch
    localparam int unsigned CMP_ADDR = ADDR_CMP_A + i;
    localparam int unsigned ACT_ADDR = ADDR_ACT_A + i;
    localparam int unsigned FRC_LSB  = 2 * i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_sh[i]  <= '0;
        cmp_act[i] <= '0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(CMP_ADDR)) cmp_sh[i] <= wr_data;
        if (zero_tick) cmp_act[i] <= cmp_sh[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_word[i] <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(ACT_ADDR)) begin
        act_word[i].on_zro  <= wr_data[1:0];
        act_word[i].on_prd  <= wr_data[3:2];
        act_word[i].on_cmpa <= wr_data[5:4];
        act_word[i].on_cmpb <= wr_data[9:8];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frc_sh[i]  <= '0;
        frc_act[i] <= '0;
      end else begin
        if (frc_wr) frc_sh[i] <= wr_data[FRC_LSB +: FRC_SH_W];
        if (frc_load) frc_act[i] <= frc_sh[i];
      end
    end
  end

endmodule

// File: rtl/pwmq_match.sv
module pwmq_match
  import pwmq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0]            cnt,
  input  logic                        cnt_up,
  input  logic [N_OUT-1:0][CNT_W-1:0] cmp_act,
  output logic [N_OUT-1:0]            hit_up
);

  for (genvar i = 0; i < N_OUT; i++) begin : g_hit
    assign hit_up[i] = cnt_up && (cnt == cmp_act[i]);
  end

endmodule

// File: rtl/pwmq_channel.sv
module pwmq_channel
  import pwmq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             evt_zero,
  input  logic             evt_period,
  input  logic [N_OUT-1:0] hit_up,
  input  act_word_t        act_word,
  input  logic [1:0]       frc,
  output logic [1:0]       code,
  output logic             lvl_q,
  output logic             pwm_o
);

  assign code = tick ? pick_action(act_word, evt_zero, evt_period, hit_up[0], hit_up[1])
                     : ACT_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else if (tick) lvl_q <= apply_action(lvl_q, code);
  end

  always_comb begin
    if (force_on(frc)) pwm_o = frc[1];
    else               pwm_o = lvl_q;
  end

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwmq_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cnt_up,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pwm_a,
  output logic              pwm_b
);

  logic [N_OUT-1:0][CNT_W-1:0] cmp_sh;
  logic [N_OUT-1:0][CNT_W-1:0] cmp_act;
  act_word_t [N_OUT-1:0]       act_word;
  logic [N_OUT-1:0][1:0]       frc_act;
  logic [N_OUT-1:0]            hit_up;
  logic [N_OUT-1:0][1:0]       code;
  logic [N_OUT-1:0]            lvl_q;
  logic [N_OUT-1:0]            pwm_o;

  pwmq_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt_zero(evt_zero),
    .evt_period(evt_period), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmp_sh(cmp_sh), .cmp_act(cmp_act), .act_word(act_word), .frc_act(frc_act)
  );

  pwmq_match #(.CNT_W(CNT_W)) i_match (
    .cnt(cnt), .cnt_up(cnt_up), .cmp_act(cmp_act), .hit_up(hit_up)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    pwmq_channel i_chan (
      .clk(clk), .rst_n(rst_n), .tick(tick), .evt_zero(evt_zero),
      .evt_period(evt_period), .hit_up(hit_up), .act_word(act_word[i]),
      .frc(frc_act[i]), .code(code[i]), .lvl_q(lvl_q[i]), .pwm_o(pwm_o[i])
    );
  end

  assign pwm_a = pwm_o[0];
  assign pwm_b = pwm_o[1];

endmodule

// File: rtl/pwmq_checker.sv
module pwmq_checker
  import pwmq_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick,
  input logic                        evt_zero,
  input logic                        pwm_a,
  input logic                        pwm_b,
  input logic [N_OUT-1:0][CNT_W-1:0] cmp_sh,
  input logic [N_OUT-1:0][CNT_W-1:0] cmp_act,
  input logic [N_OUT-1:0][1:0]       frc_act,
  input logic [N_OUT-1:0][1:0]       code,
  input logic [N_OUT-1:0]            lvl_q
);

  // R1: outputs leave reset low
  a_r1_reset_low: assert property (@(posedge clk) $rose(rst_n) |-> !pwm_a && !pwm_b);

  // R2: a no-action tick keeps the underlying levels
  a_r2_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
    tick && code[0] == ACT_NONE && code[1] == ACT_NONE |=> $stable(lvl_q));

  // R6: nothing moves without a tick
  a_r6_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pwm_a) && $stable(pwm_b));

  // R7: active compares only change at a zero tick, and then take the shadow
  a_r7_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && evt_zero) |=> $stable(cmp_act));
  a_r7_cmp_load: assert property (@(posedge clk) disable iff (!rst_n)
    tick && evt_zero |=> cmp_act == $past(cmp_sh));

  // R8: an active force fixes the output level
  a_r8_force_a_low:  assert property (@(posedge clk) disable iff (!rst_n)
    frc_act[0] == 2'b01 |-> !pwm_a);
  a_r8_force_a_high: assert property (@(posedge clk) disable iff (!rst_n)
    frc_act[0] == 2'b10 |-> pwm_a);
  a_r8_force_b_low:  assert property (@(posedge clk) disable iff (!rst_n)
    frc_act[1] == 2'b01 |-> !pwm_b);
  a_r8_force_b_high: assert property (@(posedge clk) disable iff (!rst_n)
    frc_act[1] == 2'b10 |-> pwm_b);

  // R9: force codes only become active on a tick
  a_r9_force_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(frc_act));

  // R10: the action level keeps following actions under a force
  a_r10_hidden_high: assert property (@(posedge clk) disable iff (!rst_n)
    code[0] == ACT_HIGH |=> lvl_q[0]);
  a_r10_hidden_low: assert property (@(posedge clk) disable iff (!rst_n)
    code[1] == ACT_LOW |=> !lvl_q[1]);

endmodule

bind pwm_action_qual pwmq_checker #(.CNT_W(CNT_W)) i_pwmq_checker (
  .clk(clk), .rst_n(rst_n), .tick(tick), .evt_zero(evt_zero),
  .pwm_a(pwm_a), .pwm_b(pwm_b), .cmp_sh(cmp_sh), .cmp_act(cmp_act),
  .frc_act(frc_act), .code(code), .lvl_q(lvl_q)
);

// File: tb/test_pwm_action_qual.sv
`timescale 1ns/1ps
module test_pwm_action_qual;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] cnt = '0;
  logic        cnt_up = 1'b0;
  logic        evt_zero = 1'b0;
  logic        evt_period = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench view of the block
  logic        m_q [2];
  logic [1:0]  m_f [2];
  logic [15:0] m_csh [2];
  logic [15:0] m_cact [2];
  logic [9:0]  m_act [2];
  logic [1:0]  m_fsh [2];
  logic [1:0]  m_mode;

  always #2.5 clk = ~clk;

  pwm_action_qual i_pwm_action_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_up(cnt_up),
    .evt_zero(evt_zero), .evt_period(evt_period), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_out(input int i);
    if (m_f[i] == 2'b01) return 1'b0;
    if (m_f[i] == 2'b10) return 1'b1;
    return m_q[i];
  endfunction

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    tick = 0; evt_zero = 0; evt_period = 0;
    wr_en = 1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      0: m_csh[0] = d;
      1: m_csh[1] = d;
      2: m_act[0] = d[9:0];
      3: m_act[1] = d[9:0];
      4: begin m_fsh[0] = d[1:0]; m_fsh[1] = d[3:2]; m_mode = d[7:6]; end
      default: ;
    endcase
  endtask

  task automatic step(input logic [15:0] c, input logic z, input logic p,
                      input logic up, input logic tk, input string tag);
    logic ha, hb, ld;
    logic [1:0] cd;
    @(negedge clk);
    cnt = c; evt_zero = z; evt_period = p; cnt_up = up; tick = tk;
    if (tk) begin
      ha = up && (c == m_cact[0]);
      hb = up && (c == m_cact[1]);
      for (int i = 0; i < 2; i++) begin
        cd = 2'b00;
        if (z && m_act[i][1:0] != 0) cd = m_act[i][1:0];
        if (p && m_act[i][3:2] != 0) cd = m_act[i][3:2];
        if (ha && m_act[i][5:4] != 0) cd = m_act[i][5:4];
        if (hb && m_act[i][9:8] != 0) cd = m_act[i][9:8];
        if (cd == 2'b01) m_q[i] = 1'b0;
        else if (cd == 2'b10) m_q[i] = 1'b1;
        else if (cd == 2'b11) m_q[i] = !m_q[i];
      end
      if (z) begin m_cact[0] = m_csh[0]; m_cact[1] = m_csh[1]; end
      ld = (m_mode == 2'd3) || (m_mode == 2'd0 && z) || (m_mode == 2'd1 && p) ||
           (m_mode == 2'd2 && (z || p));
      if (ld) begin m_f[0] = m_fsh[0]; m_f[1] = m_fsh[1]; end
    end
    @(negedge clk);
    chk({tag, " out A"}, pwm_a, exp_out(0));
    chk({tag, " out B"}, pwm_b, exp_out(1));
    tick = 0; evt_zero = 0; evt_period = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_q[i] = 0; m_f[i] = 0; m_csh[i] = 0; m_cact[i] = 0; m_act[i] = 0; m_fsh[i] = 0;
    end
    m_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset A", pwm_a, 1'b0);
    chk("R1 reset B", pwm_b, 1'b0);
    // R1: zero compares and words: a zero tick at count 0 counting up does nothing
    step(16'd0, 1, 0, 1, 1, "R1 idle after reset");

    // R2: every code on the zero event, from both starting levels
    for (int c = 0; c < 4; c++) begin
      wr(2, 16'(c)); wr(3, 16'(3 - c));
      step(16'd0, 1, 0, 1, 1, "R2 zero code");
      step(16'd0, 1, 0, 1, 1, "R2 zero code again");
    end
    // R3: every code on the period event
    wr(2, 16'h0); wr(3, 16'h0);
    for (int c = 0; c < 4; c++) begin
      wr(2, 16'(c << 2)); wr(3, 16'((c ^ 1) << 2));
      step(16'd40, 0, 1, 1, 1, "R3 period code");
      step(16'd40, 0, 1, 0, 1, "R3 period code again");
    end

    // R4: compare matches, only while counting up
    wr(0, 16'd7); wr(1, 16'd9);
    step(16'd0, 1, 0, 1, 1, "R7 load compares");
    for (int c = 0; c < 16; c++) begin
      wr(2, 16'(((c & 3) << 4) | ((c >> 2) << 8)));
      wr(3, 16'(((c >> 2) << 4) | ((c & 3) << 8)));
      step(16'd7, 0, 0, 1, 1, "R4 compare A up");
      step(16'd9, 0, 0, 1, 1, "R4 compare B up");
      step(16'd7, 0, 0, 0, 1, "R4 compare A down ignored");
      step(16'd9, 0, 0, 0, 1, "R4 compare B down ignored");
    end

    // R5: all four events on one tick, every code combination
    wr(0, 16'd12); wr(1, 16'd12);
    step(16'd0, 1, 0, 1, 1, "R7 load equal compares");
    for (int k = 0; k < 256; k++) begin
      wr(2, 16'(((k >> 6) << 8) | (((k >> 4) & 3) << 4) | (((k >> 2) & 3) << 2) | (k & 3)));
      wr(3, 16'(((k & 3) << 8) | (((k >> 2) & 3) << 4) | (((k >> 4) & 3) << 2) | (k >> 6)));
      step(16'd12, 1, 1, 1, 1, "R5 priority");
    end

    // R6: no tick, no change
    wr(2, 16'h033F); wr(3, 16'h033F);
    for (int k = 0; k < 4; k++) step(16'd12, 1, 1, 1, 0, "R6 no tick");

    // R7: compare shadow write applies only after a zero tick
    wr(2, 16'h0030); wr(3, 16'h0300);
    wr(0, 16'd20); wr(1, 16'd20);
    step(16'd20, 0, 0, 1, 1, "R7 shadow not yet active");
    step(16'd12, 0, 0, 1, 1, "R7 old compare still active");
    step(16'd20, 1, 0, 1, 1, "R7 zero tick uses old value");
    step(16'd20, 0, 0, 1, 1, "R7 new compare active");

    // R8, R9, R10: force codes against reload modes, hidden toggling underneath
    wr(2, 16'h000C); wr(3, 16'h0004);
    for (int md = 0; md < 4; md++) begin
      for (int fc = 0; fc < 4; fc++) begin
        wr(4, 16'((md << 6) | ((3 - fc) << 2) | fc));
        step(16'd3, 0, 0, 1, 1, "R9 plain tick");
        step(16'd50, 0, 1, 1, 1, "R9 period tick");
        step(16'd0, 1, 0, 1, 1, "R9 zero tick");
        step(16'd50, 0, 1, 1, 1, "R10 hidden toggle");
        step(16'd3, 0, 0, 1, 0, "R8 hold without tick");
      end
      wr(4, 16'(md << 6));
      step(16'd0, 1, 1, 1, 1, "R10 release");
    end

    // free-running up-down count: period 15, compares shifting
    wr(4, 16'h00C0);
    wr(2, 16'h0112); wr(3, 16'h0216);
    wr(0, 16'd4); wr(1, 16'd11);
    for (int r = 0; r < 6; r++) begin
      for (int v = 0; v < 30; v++) begin
        int cv;
        cv = (v < 15) ? v : 30 - v;
        step(16'(cv), cv == 0, cv == 15, v < 15, (v % 3) != 2, "R4 up-down run");
      end
      wr(0, 16'(2 + r)); wr(1, 16'(13 - r));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule